// File: doc/BRIEF.md
# Condition Field Mask-Compare Unit

This unit executes four related instructions that test condition-register fields against a pattern. Each instruction supplies a 4-bit mask and a 4-bit mode. For each of the four positions of a 4-bit data nibble, the unit forms a match term. A term is set when its mask bit is set and its mode bit equals the data bit.

A 2-bit sub-opcode chooses one of four routings:
- One condition field is reduced to a single bit, placed in the least significant bit of an integer result.
- The least significant bit of an integer is used as the data for all four positions, and the terms are written into a whole condition field.
- One condition field is compared, and the terms are copied into another field.
- One condition field is reduced to a single bit, written into one chosen bit of the condition register.

The single-bit reductions are an AND or an OR of the four terms, chosen by a flag in the instruction.

The compare logic is combinational. The results and write enables are registered once, so they appear one clock after a valid instruction is presented. When no field or bit is written, the condition register output is a copy of the incoming register.

Top module: `cfm_unit`

## Requirements
- R1: After synchronous reset, `int_o`, `cr_o`, `int_we_o`, `cr_we_o` and `illegal_o` are all zero.
- R2: Instruction bit 26 (bits numbered from the MSB, bit 0 = `insn_i[31]`) must be 0. If it is 1 on a valid instruction, the next cycle shows `illegal_o`=1, both write enables at 0, `int_o`=0 and `cr_o` equal to the incoming register.
- R3: Each match term n_i (i=0..3, MSB-first) is mask[i] AND (mode[i]==data[i]). Mask bit i is instruction bit 12+i. Mode bit i is instruction bit 27+i.
- R4: Sub-opcode bits 19,20 = 00 selects the condition-to-integer routing. Its data is the field numbered by bits 16-18. `int_o` bit 0 carries the reduction, bits 63:1 are zero, `int_we_o`=1 and `cr_we_o`=0.
- R5: The flag in bit 11 picks the reduction. Flag 1 gives the OR of n0..n3. Flag 0 gives the AND of n0..n3.
- R6: Sub-opcode 01 selects the integer-to-condition routing. Its data is `src_i[0]` replicated to all four positions, or zero when the register number in bits 6-10 is 0. n0..n3 are written into the field numbered by bits 16-18.
- R7: Sub-opcode 10 selects the field-to-field routing. It compares the field numbered by bits 16-18 and writes n0..n3 into the field numbered by bits 6-8. All other register bits keep their values.
- R8: Sub-opcode 11 selects the single-bit routing. Bits 8-10 give the target field and bits 6-7 the bit index, counted MSB-first inside the field. Only that bit takes the reduction.
- R9: Results appear exactly one cycle after `valid_i`. A cycle with `valid_i`=0 produces no write enable and no illegal flag, and never raises both write enables at once.
- R10: Condition field k occupies `cr_i[4k+3:4k]`, with `cr_i[4k+3]` as its MSB-first position 0. Field 0 is therefore the least significant nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Decoded instruction word, MSB-first bit k at `insn_i[31-k]` |
| cr_i | input | 32 | Current condition register |
| src_i | input | 64 | Integer source operand |
| int_o | output | 64 | Integer result |
| int_we_o | output | 1 | Integer result write enable |
| cr_o | output | 32 | Updated condition register |
| cr_we_o | output | 1 | Condition register write enable |
| illegal_o | output | 1 | Illegal encoding flag |

## Verification
The hardest case to reach from the ports is the single-bit routing. There, a field number, an MSB-first bit index and a reduction flag must all line up, and the touched bit must be the only one that differs in an otherwise arbitrary register.

The stimulus first drives directed encodings that hit field 0 and field 7 with every bit index, and with masks of all-ones, all-zeros and a single bit. It then drives a long stream of random instruction words and register values, so that every routing meets many field, bit and flag combinations. The same stream exercises the integer-to-condition routing with register number 0 against a nonzero source.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
    localparam int CR_W   = 32;
    localparam int INT_W  = 64;
    localparam int FLD_W  = 4;
    localparam int NFLD   = CR_W / FLD_W;
    localparam int FSEL_W = $clog2(NFLD);
    localparam int BSEL_W = $clog2(FLD_W);
    localparam int INS_W  = 32;

    typedef enum logic [1:0] {
        K_CR2INT = 2'b00,
        K_INT2CR = 2'b01,
        K_CR2CR  = 2'b10,
        K_CR2BIT = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic               any;
        logic [FLD_W-1:0]   mask;
        logic [FLD_W-1:0]   mode;
        logic [FSEL_W-1:0]  src_fld;
        logic [4:0]         dst;
        logic               illegal;
    } dec_t;

    // MSB-first instruction bit k
    function automatic logic ib(input logic [INS_W-1:0] w, input int k);
        return w[INS_W-1-k];
    endfunction

    function automatic logic [FLD_W-1:0] get_fld(input logic [CR_W-1:0] cr,
                                                 input logic [FSEL_W-1:0] f);
        return cr[f*FLD_W +: FLD_W];
    endfunction
endpackage

// File: rtl/cfm_decode.sv
module cfm_decode
    import cfm_pkg::*;
(
    input  logic [INS_W-1:0] insn,
    output dec_t             dec
);
    always_comb begin
        dec.kind    = kind_e'({ib(insn, 19), ib(insn, 20)});
        dec.any     = ib(insn, 11);
        dec.illegal = ib(insn, 26);
        for (int i = 0; i < FLD_W; i++) begin
            dec.mask[FLD_W-1-i] = ib(insn, 12 + i);
            dec.mode[FLD_W-1-i] = ib(insn, 27 + i);
        end
        for (int i = 0; i < FSEL_W; i++)
            dec.src_fld[FSEL_W-1-i] = ib(insn, 16 + i);
        for (int i = 0; i < 5; i++)
            dec.dst[4-i] = ib(insn, 6 + i);
    end
endmodule

// File: rtl/cfm_match.sv
module cfm_match
    import cfm_pkg::*;
(
    input  logic [FLD_W-1:0] mask,
    input  logic [FLD_W-1:0] mode,
    input  logic [FLD_W-1:0] data,
    input  logic             any,
    output logic [FLD_W-1:0] terms,
    output logic             red
);
    for (genvar g = 0; g < FLD_W; g++) begin : g_term
        assign terms[g] = mask[g] & (mode[g] ~^ data[g]);
    end
    assign red = any ? (|terms) : (&terms);
endmodule

// File: rtl/cfm_route.sv
module cfm_route
    import cfm_pkg::*;
(
    input  dec_t              dec,
    input  logic [CR_W-1:0]   cr_in,
    input  logic [INT_W-1:0]  src,
    input  logic [FLD_W-1:0]  terms,
    input  logic              red,
    output logic [FLD_W-1:0]  data,
    output logic [INT_W-1:0]  int_res,
    output logic              int_we,
    output logic [CR_W-1:0]   cr_res,
    output logic              cr_we
);
    logic [FSEL_W-1:0] bit_fld;
    logic [BSEL_W-1:0] bit_idx;
    logic [FSEL_W-1:0] ff_fld;

    assign bit_fld = dec.dst[FSEL_W-1:0];
    assign bit_idx = dec.dst[4 -: BSEL_W];
    assign ff_fld  = dec.dst[4 -: FSEL_W];

    always_comb begin
        if (dec.kind == K_INT2CR)
            data = (dec.dst == '0) ? '0 : {FLD_W{src[0]}};
        else
            data = get_fld(cr_in, dec.src_fld);
    end

    always_comb begin
        int_res = '0;
        int_we  = 1'b0;
        cr_res  = cr_in;
        cr_we   = 1'b0;
        unique case (dec.kind)
            K_CR2INT: begin
                int_res[0] = red;
                int_we     = 1'b1;
            end
            K_INT2CR: begin
                cr_res[dec.src_fld*FLD_W +: FLD_W] = terms;
                cr_we = 1'b1;
            end
            K_CR2CR: begin
                cr_res[ff_fld*FLD_W +: FLD_W] = terms;
                cr_we = 1'b1;
            end
            K_CR2BIT: begin
                cr_res[bit_fld*FLD_W + (FLD_W-1) - int'(bit_idx)] = red;
                cr_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfm_unit.sv
module cfm_unit
    import cfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [INS_W-1:0]  insn_i,
    input  logic [CR_W-1:0]   cr_i,
    input  logic [INT_W-1:0]  src_i,
    output logic [INT_W-1:0]  int_o,
    output logic              int_we_o,
    output logic [CR_W-1:0]   cr_o,
    output logic              cr_we_o,
    output logic              illegal_o
);
    dec_t              dec;
    logic [FLD_W-1:0]  data, terms;
    logic              red;
    logic [INT_W-1:0]  int_res;
    logic [CR_W-1:0]   cr_res;
    logic              int_we, cr_we, go;
    kind_e             kind_q;
    logic [CR_W-1:0]   cr_in_q;

    cfm_decode u_dec (.insn(insn_i), .dec(dec));

    cfm_match u_match (
        .mask(dec.mask), .mode(dec.mode), .data(data), .any(dec.any),
        .terms(terms), .red(red)
    );

    cfm_route u_route (
        .dec(dec), .cr_in(cr_i), .src(src_i), .terms(terms), .red(red),
        .data(data), .int_res(int_res), .int_we(int_we),
        .cr_res(cr_res), .cr_we(cr_we)
    );

    assign go = valid_i & ~dec.illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_o     <= '0;
            int_we_o  <= 1'b0;
            cr_o      <= '0;
            cr_we_o   <= 1'b0;
            illegal_o <= 1'b0;
            kind_q    <= K_CR2INT;
            cr_in_q   <= '0;
        end else begin
            int_o     <= (go && int_we) ? int_res : '0;
            int_we_o  <= go & int_we;
            cr_o      <= (go && cr_we) ? cr_res : cr_i;
            cr_we_o   <= go & cr_we;
            illegal_o <= valid_i & dec.illegal;
            kind_q    <= dec.kind;
            cr_in_q   <= cr_i;
        end
    end

    // R9: the two destinations are never written together
    p_one_dest_r9: assert property (@(posedge clk) disable iff (rst)
        !(int_we_o && cr_we_o));

    // R2: an illegal encoding writes nothing
    p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!int_we_o && !cr_we_o));

    // R4: integer result carries a single bit
    p_int_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        int_we_o |-> (int_o[INT_W-1:1] == '0));

    // R9: an idle cycle yields no writes next cycle
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!int_we_o && !cr_we_o && !illegal_o));

    // R8: single-bit routing disturbs at most one register bit
    p_single_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (cr_we_o && kind_q == K_CR2BIT) |-> ($countones(cr_o ^ cr_in_q) <= 1));

    // R7: field routings disturb at most one field's worth of bits
    p_field_span_r7: assert property (@(posedge clk) disable iff (rst)
        (cr_we_o && (kind_q == K_CR2CR || kind_q == K_INT2CR))
            |-> ($countones(cr_o ^ cr_in_q) <= FLD_W));
endmodule

// File: tb/cfm_unit_bench.sv
module cfm_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [31:0] cr_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] int_o;
    logic        int_we_o, cr_we_o, illegal_o;
    logic [31:0] cr_o;

    int checks = 0;
    int failures = 0;

    // expected outputs for the next sample
    logic [63:0] e_int;
    logic        e_iwe, e_cwe, e_ill;
    logic [31:0] e_cr;
    string       e_tag;

    always #5 clk = ~clk;

    cfm_unit u_cfm_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i), .cr_i(cr_i),
        .src_i(src_i), .int_o(int_o), .int_we_o(int_we_o), .cr_o(cr_o),
        .cr_we_o(cr_we_o), .illegal_o(illegal_o)
    );

    function automatic logic [31:0] mk(input int kind, input int m, input int mask,
                                       input int sf, input int dst, input int mode,
                                       input int b26);
        logic [31:0] w = '0;
        for (int k = 0; k < 6; k++) w[31-k] = 1'((19 >> (5-k)) & 1);
        for (int j = 0; j < 5; j++) w[31-(6+j)]  = 1'((dst >> (4-j)) & 1);
        w[31-11] = 1'(m);
        for (int j = 0; j < 4; j++) w[31-(12+j)] = 1'((mask >> (3-j)) & 1);
        for (int j = 0; j < 3; j++) w[31-(16+j)] = 1'((sf >> (2-j)) & 1);
        w[31-19] = 1'((kind >> 1) & 1);
        w[31-20] = 1'(kind & 1);
        w[31-26] = 1'(b26);
        for (int j = 0; j < 4; j++) w[31-(27+j)] = 1'((mode >> (3-j)) & 1);
        return w;
    endfunction

    // behavioural reference: computes next expected outputs
    task automatic model(input logic v, input logic [31:0] w,
                         input logic [31:0] cr, input logic [63:0] s);
        int kind, sf, r5, fld, bi;
        logic m;
        logic d[4];
        logic n[4];
        logic r_and, r_or, red;
        e_int = '0; e_iwe = 0; e_cwe = 0; e_ill = 0; e_cr = cr;
        kind = 2 * int'(w[31-19]) + int'(w[31-20]);
        m  = w[31-11];
        sf = 4 * int'(w[31-16]) + 2 * int'(w[31-17]) + int'(w[31-18]);
        r5 = 0;
        for (int j = 0; j < 5; j++) r5 = r5 * 2 + int'(w[31-(6+j)]);
        case (kind)
            0: e_tag = m ? "R5/R4" : "R4/R10";
            1: e_tag = "R6/R3";
            2: e_tag = "R7/R3";
            default: e_tag = "R8/R5";
        endcase
        if (!v) begin e_tag = "R9"; return; end
        if (w[31-26]) begin e_ill = 1; e_tag = "R2"; return; end
        for (int i = 0; i < 4; i++) begin
            if (kind == 1) d[i] = (r5 == 0) ? 1'b0 : s[0];
            else d[i] = cr[4*sf + 3 - i];
        end
        r_and = 1; r_or = 0;
        for (int i = 0; i < 4; i++) begin
            n[i] = w[31-(12+i)] && (w[31-(27+i)] == d[i]);
            r_and = r_and && n[i];
            r_or  = r_or || n[i];
        end
        red = m ? r_or : r_and;
        case (kind)
            0: begin e_int[0] = red; e_iwe = 1; end
            1: begin for (int i = 0; i < 4; i++) e_cr[4*sf+3-i] = n[i]; e_cwe = 1; end
            2: begin
                fld = r5 / 4;
                for (int i = 0; i < 4; i++) e_cr[4*fld+3-i] = n[i];
                e_cwe = 1;
            end
            default: begin
                fld = r5 % 8; bi = r5 / 8;
                e_cr[4*fld+3-bi] = red; e_cwe = 1;
            end
        endcase
    endtask

    task automatic compare();
        checks++;
        if (int_o !== e_int || int_we_o !== e_iwe || cr_o !== e_cr ||
            cr_we_o !== e_cwe || illegal_o !== e_ill) begin
            failures++;
            $display("FAIL %s actual int=%h iwe=%b cr=%h cwe=%b ill=%b expected int=%h iwe=%b cr=%h cwe=%b ill=%b",
                     e_tag, int_o, int_we_o, cr_o, cr_we_o, illegal_o,
                     e_int, e_iwe, e_cr, e_cwe, e_ill);
        end
    endtask

    // apply at negedge, compare at following negedge
    task automatic step(input logic v, input logic [31:0] w,
                        input logic [31:0] cr, input logic [63:0] s);
        valid_i = v; insn_i = w; cr_i = cr; src_i = s;
        model(v, w, cr, s);
        @(negedge clk);
        compare();
    endtask

    initial begin : watchdog
        #1500000;
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        e_int = '0; e_iwe = 0; e_cr = '0; e_cwe = 0; e_ill = 0; e_tag = "R1";
        compare();
        rst = 1'b0;

        // R10: field 0 is the low nibble, field 7 the high nibble
        step(1, mk(0, 0, 4'hF, 0, 3, 4'hA, 0), 32'h5000_000A, '0);
        step(1, mk(0, 0, 4'hF, 7, 3, 4'h5, 0), 32'h5000_000A, '0);
        step(1, mk(0, 0, 4'hF, 7, 3, 4'hA, 0), 32'h5000_000A, '0);
        // R5: OR reduction with a single mask bit
        step(1, mk(0, 1, 4'h8, 2, 1, 4'h8, 0), 32'h0000_0800, '0);
        step(1, mk(0, 1, 4'h0, 2, 1, 4'h8, 0), 32'h0000_0800, '0);
        // R6: register number zero forces data 0, nonzero uses src bit 0
        step(1, mk(1, 0, 4'hF, 4, 0, 4'h3, 0), 32'hFFFF_FFFF, 64'h1);
        step(1, mk(1, 0, 4'hF, 4, 9, 4'h3, 0), 32'hFFFF_FFFF, 64'h1);
        step(1, mk(1, 0, 4'hC, 0, 9, 4'h0, 0), 32'h1234_5678, 64'h0);
        // R7: field to field
        step(1, mk(2, 0, 4'hF, 1, 7 << 2, 4'h9, 0), 32'h0000_0090, '0);
        // R8: every bit index in fields 0 and 7
        for (int b = 0; b < 4; b++) begin
            step(1, mk(3, 1, 4'hF, 3, (b << 3) | 0, 4'h0, 0), 32'h0000_0000, '0);
            step(1, mk(3, 0, 4'hF, 3, (b << 3) | 7, 4'h0, 0), 32'hFFFF_0FFF, '0);
        end
        // R2: illegal encodings
        step(1, mk(2, 0, 4'hF, 1, 5, 4'h9, 1), 32'hDEAD_BEEF, '0);
        step(1, mk(0, 1, 4'hF, 1, 5, 4'h9, 1), 32'hDEAD_BEEF, '0);
        // R9: idle cycles
        step(0, mk(2, 0, 4'hF, 1, 5, 4'h9, 0), 32'hCAFE_F00D, '0);
        step(0, mk(0, 0, 4'hF, 1, 5, 4'h9, 0), 32'hCAFE_F00D, '0);

        // random stream covering all routings
        for (int t = 0; t < 3000; t++) begin
            logic [31:0] w;
            w = $urandom;
            if ((t % 8) != 0) w[31-26] = 1'b0;
            if ((t % 16) == 1) w[31-10 +: 5] = '0;
            step(($urandom % 10) != 0, w, $urandom, {$urandom, $urandom});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule